// File: doc/BRIEF.md
# Interleaved DMA address generator

This block turns a compact description of a strided transfer into a stream of source and destination byte addresses, one pair per byte. A frame is an ordered list of chunks, and each chunk gives a byte count and a gap. The frame is walked a programmed number of times. Addresses carry on from one frame to the next and are not reset between frames. Each side (source and destination) has its own increment flag and scatter flag. A side that does not increment stays on its start address. A side that increments without scattering runs contiguously and ignores gaps. A side that increments and scatters skips forward by the chunk's gap after the chunk's last byte.

The chunk table is written through a small write port while the block is idle. A `start` pulse latches the start addresses, flags, frame count and chunk count. The block then presents address pairs under a valid/ready handshake and pulses `done` when the transfer is complete.

States: `ST_IDLE` waits for a start. `ST_FETCH` reads the current chunk entry. `ST_BEAT` presents one address pair per accepted byte. `ST_FIN` drives the one-cycle `done` pulse. The transitions are:
- idle→fin on a start with zero frames or zero chunks.
- idle→fetch on any other start.
- fetch→beat when the chunk size is non-zero.
- fetch→fetch for a zero-size chunk that is not the last one.
- fetch→fin for a zero-size last chunk of the last frame.
- beat→fetch after the last byte of a chunk, unless it is the final one.
- beat→fin after the final byte.
- fin→idle unconditionally.

Top module: `ixdma_addr_gen`

## Requirements
- R1: After reset, `beat_valid`, `done` and `busy` are all low.
- R2: The first address pair of a transfer equals the latched `src_start`/`dst_start`. The chunk count is legal from 0 to 8, and table indices run 0 to 7.
- R3: Within a chunk, an incrementing side advances by exactly 1 per accepted beat. Exactly one beat is issued per byte of chunk size. Addresses wrap modulo 2^32.
- R4: On an incrementing side with scatter set, the first address of the next chunk is the last byte's address plus 1 plus the finished chunk's gap.
- R5: On an incrementing side with scatter clear, gaps are ignored and the addresses are contiguous.
- R6: On a side with increment clear, every beat carries its start address, whatever its scatter flag is.
- R7: The chunk list is walked in index order once per frame, for the programmed number of frames. Each frame continues from the address where the previous frame left off.
- R8: A zero-size chunk issues no beats, but its gap is still applied on scattering sides. Each zero-size chunk takes one cycle in `ST_FETCH`.
- R9: A start with frame count 0 or chunk count 0 issues no beats. In that case `done` is high in the cycle after the start.
- R10: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `beat_src` and `beat_dst` hold.
- R11: `done` is a single-cycle pulse. It appears one cycle after the final beat is accepted, plus one cycle for each trailing zero-size chunk of the last frame.
- R12: A `start` while a transfer is running is ignored. So are table writes: they are accepted only in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| src_start | input | 32 | Source address of the first byte |
| dst_start | input | 32 | Destination address of the first byte |
| src_inc | input | 1 | Source address increments |
| src_scat | input | 1 | Source applies chunk gaps |
| dst_inc | input | 1 | Destination address increments |
| dst_scat | input | 1 | Destination applies chunk gaps |
| num_frames | input | 16 | Number of frame repetitions |
| num_chunks | input | 4 | Chunks per frame, 0 to 8 |
| tbl_we | input | 1 | Chunk table write strobe |
| tbl_idx | input | 3 | Chunk table entry to write |
| tbl_size | input | 16 | Byte count of the entry |
| tbl_gap | input | 16 | Gap of the entry in bytes |
| beat_ready | input | 1 | Consumer accepts the current pair |
| beat_valid | output | 1 | Address pair is valid |
| beat_src | output | 32 | Source byte address |
| beat_dst | output | 32 | Destination byte address |
| busy | output | 1 | Transfer in progress (fetch or beat) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that `num_chunks` never exceeds the table depth when a start is taken. The stimulus only programs chunk counts from 0 to 8, so it stays within that limit.

The assertions also assume that the consumer's ready signal may stall for any number of cycles. The bench lowers ready on every third cycle so that stalls land inside chunks.

Table contents are kept small enough for each transfer to finish in well under a hundred beats. Zero-size entries are placed at the start, middle and end of frames.

// File: rtl/ixdma_pkg.sv
package ixdma_pkg;
    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_LEN_W      = 16;
    localparam int unsigned DEF_FRAME_W    = 16;
    localparam int unsigned DEF_MAX_CHUNKS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_BEAT  = 2'd2,
        ST_FIN   = 2'd3
    } ixg_state_e;
endpackage

// File: rtl/ixdma_chunk_tbl.sv
module ixdma_chunk_tbl #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LEN_W = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LEN_W-1:0] wr_size,
    input  logic [LEN_W-1:0] wr_gap,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LEN_W-1:0] rd_size,
    output logic [LEN_W-1:0] rd_gap
);
    logic [LEN_W-1:0] size_q [DEPTH];
    logic [LEN_W-1:0] gap_q  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                size_q[e] <= '0;
                gap_q[e]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                size_q[e] <= wr_size;
                gap_q[e]  <= wr_gap;
            end
        end
    end

    assign rd_size = size_q[rd_idx];
    assign rd_gap  = gap_q[rd_idx];
endmodule

// File: rtl/ixdma_addr_side.sv
module ixdma_addr_side #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              inc_en,
    input  logic              scat_en,
    input  logic              step,
    input  logic              chunk_end,
    input  logic [LEN_W-1:0]  gap,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              inc_q, scat_q;
    logic [ADDR_W-1:0] gap_add;

    always_comb begin
        gap_add = (scat_q && chunk_end) ? {{(ADDR_W-LEN_W){1'b0}}, gap} : '0;
        addr_d  = addr_q;
        if (load) begin
            addr_d = start_addr;
        end else if (inc_q && (step || chunk_end)) begin
            addr_d = addr_q + ADDR_W'(step) + gap_add;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            inc_q  <= 1'b0;
            scat_q <= 1'b0;
        end else begin
            addr_q <= addr_d;
            if (load) begin
                inc_q  <= inc_en;
                scat_q <= scat_en;
            end
        end
    end

    assign addr = addr_q;

    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_q && !load) |=> $stable(addr_q)); // R6

    AST_CONTIG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_q && !scat_q && step && !load) |=> (addr_q == $past(addr_q) + ADDR_W'(1))); // R5
endmodule

// File: rtl/ixdma_addr_gen.sv
module ixdma_addr_gen
    import ixdma_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LEN_W      = DEF_LEN_W,
    parameter int unsigned FRAME_W    = DEF_FRAME_W,
    parameter int unsigned MAX_CHUNKS = DEF_MAX_CHUNKS,
    localparam int unsigned IDX_W = $clog2(MAX_CHUNKS),
    localparam int unsigned CNT_W = $clog2(MAX_CHUNKS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  src_start,
    input  logic [ADDR_W-1:0]  dst_start,
    input  logic               src_inc,
    input  logic               src_scat,
    input  logic               dst_inc,
    input  logic               dst_scat,
    input  logic [FRAME_W-1:0] num_frames,
    input  logic [CNT_W-1:0]   num_chunks,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic [LEN_W-1:0]   tbl_size,
    input  logic [LEN_W-1:0]   tbl_gap,
    input  logic               beat_ready,
    output logic               beat_valid,
    output logic [ADDR_W-1:0]  beat_src,
    output logic [ADDR_W-1:0]  beat_dst,
    output logic               busy,
    output logic               done
);
    ixg_state_e state_q, state_d;

    logic [FRAME_W-1:0] frames_left_q;
    logic [CNT_W-1:0]   nchunks_q;
    logic [IDX_W-1:0]   cidx_q;
    logic [LEN_W-1:0]   bytes_left_q;
    logic [LEN_W-1:0]   rd_size, rd_gap;
    logic               start_ok, step, chunk_end, last_chunk, last_frame;

    assign start_ok   = start && (state_q == ST_IDLE);
    assign last_chunk = ((CNT_W'(cidx_q) + CNT_W'(1)) == nchunks_q);
    assign last_frame = (frames_left_q == FRAME_W'(1));

    ixdma_chunk_tbl #(.DEPTH(MAX_CHUNKS), .LEN_W(LEN_W)) tbl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we && (state_q == ST_IDLE)),
        .wr_idx  (tbl_idx),
        .wr_size (tbl_size),
        .wr_gap  (tbl_gap),
        .rd_idx  (cidx_q),
        .rd_size (rd_size),
        .rd_gap  (rd_gap)
    );

    ixdma_addr_side #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) src_side_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_ok),
        .start_addr (src_start),
        .inc_en     (src_inc),
        .scat_en    (src_scat),
        .step       (step),
        .chunk_end  (chunk_end),
        .gap        (rd_gap),
        .addr       (beat_src)
    );

    ixdma_addr_side #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dst_side_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_ok),
        .start_addr (dst_start),
        .inc_en     (dst_inc),
        .scat_en    (dst_scat),
        .step       (step),
        .chunk_end  (chunk_end),
        .gap        (rd_gap),
        .addr       (beat_dst)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and walk strobes
    always_comb begin
        state_d   = state_q;
        step      = 1'b0;
        chunk_end = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin
                    state_d = ((num_frames == '0) || (num_chunks == '0)) ? ST_FIN : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (rd_size == '0) begin
                    chunk_end = 1'b1;
                    if (last_chunk && last_frame) state_d = ST_FIN;
                end else begin
                    state_d = ST_BEAT;
                end
            end
            ST_BEAT: begin
                if (beat_ready) begin
                    step = 1'b1;
                    if (bytes_left_q == LEN_W'(1)) begin
                        chunk_end = 1'b1;
                        state_d   = (last_chunk && last_frame) ? ST_FIN : ST_FETCH;
                    end
                end
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        beat_valid = (state_q == ST_BEAT);
        busy       = (state_q == ST_FETCH) || (state_q == ST_BEAT);
        done       = (state_q == ST_FIN);
    end

    // walk counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frames_left_q <= '0;
            nchunks_q     <= '0;
            cidx_q        <= '0;
            bytes_left_q  <= '0;
        end else begin
            if (start_ok) begin
                frames_left_q <= num_frames;
                nchunks_q     <= num_chunks;
                cidx_q        <= '0;
            end
            if ((state_q == ST_FETCH) && (rd_size != '0)) begin
                bytes_left_q <= rd_size;
            end else if (step) begin
                bytes_left_q <= bytes_left_q - LEN_W'(1);
            end
            if (chunk_end) begin
                if (last_chunk) begin
                    cidx_q        <= '0;
                    frames_left_q <= frames_left_q - FRAME_W'(1);
                end else begin
                    cidx_q <= cidx_q + IDX_W'(1);
                end
            end
        end
    end

    AST_CHUNKS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |-> (num_chunks <= CNT_W'(MAX_CHUNKS))); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_src) && $stable(beat_dst))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R12

    AST_ZERO_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && ((num_frames == '0) || (num_chunks == '0))) |=> (done && !beat_valid)); // R9
endmodule

// File: tb/ixdma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module ixdma_addr_gen_tb_top;
    typedef struct packed {
        logic [31:0] s0;
        logic [31:0] d0;
        logic        si;
        logic        ss;
        logic        di;
        logic        ds;
        logic [15:0] nf;
        logic [3:0]  nc;
    } cfg_t;

    // s0, d0, src_inc, src_scat, dst_inc, dst_scat, frames, chunks
    localparam cfg_t VEC [7] = '{
        '{32'h0000_1000, 32'h0000_8000, 1'b1, 1'b1, 1'b1, 1'b1, 16'd1, 4'd3}, // R3
        '{32'h0000_2000, 32'h0000_9000, 1'b1, 1'b1, 1'b1, 1'b0, 16'd2, 4'd4}, // R4
        '{32'h0000_3000, 32'h0000_A000, 1'b0, 1'b1, 1'b1, 1'b1, 16'd2, 4'd5}, // R6
        '{32'h0000_4000, 32'h0000_B000, 1'b1, 1'b1, 1'b0, 1'b1, 16'd3, 4'd8}, // R8
        '{32'hFFFF_FFFE, 32'h0000_C000, 1'b1, 1'b0, 1'b1, 1'b0, 16'd1, 4'd8}, // R5
        '{32'h0000_5000, 32'h0000_D000, 1'b1, 1'b1, 1'b1, 1'b1, 16'd0, 4'd3}, // R9
        '{32'h0000_6000, 32'h0000_E000, 1'b1, 1'b1, 1'b1, 1'b1, 16'd2, 4'd0}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_start = '0, dst_start = '0;
    logic        src_inc = 1'b0, src_scat = 1'b0, dst_inc = 1'b0, dst_scat = 1'b0;
    logic [15:0] num_frames = '0;
    logic [3:0]  num_chunks = '0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [15:0] tbl_size = '0, tbl_gap = '0;
    logic        beat_ready = 1'b0;
    logic        beat_valid, busy, done;
    logic [31:0] beat_src, beat_dst;

    always #2.5 clk = ~clk;

    ixdma_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_start(src_start), .dst_start(dst_start),
        .src_inc(src_inc), .src_scat(src_scat), .dst_inc(dst_inc), .dst_scat(dst_scat),
        .num_frames(num_frames), .num_chunks(num_chunks),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_size(tbl_size), .tbl_gap(tbl_gap),
        .beat_ready(beat_ready), .beat_valid(beat_valid),
        .beat_src(beat_src), .beat_dst(beat_dst), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] es [512];
    logic [31:0] ed [512];
    logic [15:0] tsz [8];
    logic [15:0] tgp [8];
    int n_exp;
    int trail_z;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load_tbl(input int v);
        for (int i = 0; i < 8; i++) begin
            tsz[i] = 16'((i * 3 + v) % 4);
            tgp[i] = 16'(3 + 5 * i + 7 * v);
            @(negedge clk);
            tbl_we = 1'b1; tbl_idx = 3'(i); tbl_size = tsz[i]; tbl_gap = tgp[i];
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic build(input cfg_t c);
        logic [31:0] s, d;
        s = c.s0; d = c.d0; n_exp = 0; trail_z = 0;
        for (int f = 0; f < int'(c.nf); f++) begin
            for (int ch = 0; ch < int'(c.nc); ch++) begin
                for (int b = 0; b < int'(tsz[ch]); b++) begin
                    es[n_exp] = s; ed[n_exp] = d; n_exp++;
                    if (c.si) s = s + 32'd1;
                    if (c.di) d = d + 32'd1;
                end
                if (c.si && c.ss) s = s + {16'd0, tgp[ch]};
                if (c.di && c.ds) d = d + {16'd0, tgp[ch]};
            end
        end
        if (c.nf != 0) begin
            for (int ch = int'(c.nc) - 1; ch >= 0; ch--) begin
                if (tsz[ch] != 0) break;
                trail_z++;
            end
        end
    endtask

    task automatic run(input int v, input string tag, input bit reload, input bit poke);
        cfg_t c;
        int k, since;
        bit fin, stalled, poked, rdy, exp_done;
        logic [31:0] hs, hd;
        c = VEC[v];
        if (reload) load_tbl(v);
        build(c);
        @(negedge clk);
        src_start = c.s0; dst_start = c.d0;
        src_inc = c.si; src_scat = c.ss; dst_inc = c.di; dst_scat = c.ds;
        num_frames = c.nf; num_chunks = c.nc; start = 1'b1;
        k = 0; since = 0; fin = 0; stalled = 0; poked = 0;
        for (int t = 0; t < 2000 && !fin; t++) begin
            @(negedge clk);
            since++;
            start = 1'b0; tbl_we = 1'b0;
            if (stalled) begin
                check(beat_valid && beat_src == hs && beat_dst == hd, "R10", "stall hold src",
                      beat_src, hs);
                stalled = 0;
            end
            exp_done = (k == n_exp) && (since == 1 + trail_z);
            if (done || exp_done) begin
                check(done == exp_done, "R11", "done timing", 32'(done), 32'(exp_done));
                fin = 1;
            end else begin
                rdy = (cyc % 3) != 2;
                if (poke && k == 1 && !poked) begin
                    start = 1'b1; src_start = 32'hDEAD_0000;
                    tbl_we = 1'b1; tbl_idx = 3'd0; tbl_size = 16'd9; tbl_gap = 16'd99;
                    poked = 1;
                end
                beat_ready = rdy;
                if (beat_valid) begin
                    if (rdy) begin
                        if (k < n_exp) begin
                            check(beat_src == es[k], (k == 0) ? "R2" : tag, "src", beat_src, es[k]);
                            check(beat_dst == ed[k], (k == 0) ? "R2" : tag, "dst", beat_dst, ed[k]);
                        end else begin
                            check(1'b0, "R3", "extra beat", beat_src, 32'(n_exp));
                        end
                        k++; since = 0;
                    end else begin
                        stalled = 1; hs = beat_src; hd = beat_dst;
                    end
                end
            end
        end
        if (!fin) check(1'b0, "R11", "no done", 32'(k), 32'(n_exp));
        check(k == n_exp, "R7", "beat count", 32'(k), 32'(n_exp));
        beat_ready = 1'b0; start = 1'b0; tbl_we = 1'b0;
        @(negedge clk);
        check(!done && !busy, "R11", "done single pulse", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!beat_valid && !done && !busy, "R1", "reset outputs",
              {29'd0, beat_valid, done, busy}, 32'd0);

        // vector table walk
        run(0, "R3", 1'b1, 1'b0);
        run(1, "R4", 1'b1, 1'b0);
        run(2, "R6", 1'b1, 1'b0);
        run(3, "R8", 1'b1, 1'b0);
        run(4, "R5", 1'b1, 1'b0);
        run(5, "R9", 1'b1, 1'b0);
        run(6, "R9", 1'b1, 1'b0);

        // directed: start and table write while busy are ignored (R12)
        run(1, "R12", 1'b1, 1'b1);
        run(1, "R12", 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule